// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block combines two eight-line priority arbiters into a single sixteen-line interrupt controller for a processor. Lines 0 to 7 go to the primary arbiter and lines 8 to 15 go to the secondary arbiter. The secondary arbiter does not connect to a pin of the primary. Instead, whenever the secondary holds a request that beats its own in-service lines, it raises the primary's request on cascade line 2.

When the primary holds a winning request, the block asserts the processor interrupt request. The processor then pulses an acknowledge strobe. In the cycle after the strobe, the block presents an 8-bit vector, and it marks the chosen line in service. Three poll strobes let software read a winning line number without taking the acknowledge path: one for the primary, one for the secondary, and one combined. Each of them clears the line it reports.

Each arbiter has a trigger-select register that holds one bit per line. A clear bit makes the line edge-sensitive and a set bit makes it level-sensitive. A fixed write mask keeps the reserved lines edge-sensitive. Priority is fixed, with lower line numbers winning. A request wins only when its priority is strictly higher than that of every line in service.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset the request output is low, the vector and poll outputs read 0, no line is pending or in service, and every line is edge-sensitive.
- R2: An edge-sensitive primary line records a request on a rising input edge. The interrupt output is high exactly when the lowest-numbered pending primary line is numbered below every in-service primary line. It changes in the cycle after the edge that updated that state.
- R3: External line 2 is ignored. A winning secondary request sets the primary cascade request one cycle after the secondary request is recorded.
- R4: An acknowledge with a primary winner other than line 2 yields vector {base_m, line[2:0]} on the next cycle. It moves that line from pending to in service, and an in-service line blocks itself and all higher-numbered lines.
- R5: An acknowledge with primary winner line 2 puts line 2 in service and also acknowledges the secondary winner. The vector is {base_s, secondary line}.
- R6: If the primary winner is line 2 but the secondary has no winner, the vector is {base_s, 3'd7}, and the secondary state is unchanged.
- R7: An acknowledge with no primary winner yields {base_m, 3'd7} and changes no arbiter state.
- R8: A primary poll returns the winning line number and clears that line's pending and in-service bits, without marking it in service. It returns 7 when there is no winner.
- R9: A secondary poll returns the secondary winner and clears it, and it also clears the primary's line-2 pending and in-service bits. It returns 7 when there is no winner.
- R10: A combined poll returns the primary result. If the primary winner is line 2, it instead returns 8 plus the secondary poll result.
- R11: Trigger-select writes are ANDed with 8'hF8 for the primary and 8'hDE for the secondary. A level-sensitive line's request follows its input every cycle, even after it is cleared.
- R12: An acknowledge takes precedence over any poll strobe in the same cycle, and the poll output then keeps its value. Among the polls, combined wins over primary, and primary wins over secondary.
- R13: The vector output changes only in the cycle after an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 16 | Request lines; [7:0] primary, [15:8] secondary |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| poll_m_i | input | 1 | Primary poll strobe |
| poll_s_i | input | 1 | Secondary poll strobe |
| poll_c_i | input | 1 | Combined poll strobe |
| base_m_i | input | 5 | Upper five vector bits for primary lines |
| base_s_i | input | 5 | Upper five vector bits for secondary lines |
| trig_wr_m_i | input | 1 | Write strobe for the primary trigger-select register |
| trig_wr_s_i | input | 1 | Write strobe for the secondary trigger-select register |
| trig_wdata_i | input | 8 | Trigger-select write data, 1 = level-sensitive |
| irq_o | output | 1 | Processor interrupt request |
| vector_o | output | 8 | Vector from the last acknowledge |
| poll_o | output | 4 | Line number from the last poll |

## Verification
An acknowledge can fall in the same cycle as a new rising edge on a higher-priority line, and also in the same cycle as a poll strobe. The bench provokes both at once. It holds line 5 pending, then pulses acknowledge and primary poll together while line 1 rises. The vector must name line 5, the poll output must keep its old value, and the interrupt output must be high afterwards. A second acknowledge must then name line 1. Separately, an acknowledge of cascade line 2 coincides with the secondary's still-asserted cascade request. The bench judges this by the interrupt output going low after that acknowledge.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter logic [7:0] TRIG_MASK_M = 8'hF8,
  parameter logic [7:0] TRIG_MASK_S = 8'hDE,
  parameter int CASCADE_LINE = 2,
  parameter int SPURIOUS_LINE = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_i,
  input  logic        ack_i,
  input  logic        poll_m_i,
  input  logic        poll_s_i,
  input  logic        poll_c_i,
  input  logic [4:0]  base_m_i,
  input  logic [4:0]  base_s_i,
  input  logic        trig_wr_m_i,
  input  logic        trig_wr_s_i,
  input  logic [7:0]  trig_wdata_i,
  output logic        irq_o,
  output logic [7:0]  vector_o,
  output logic [3:0]  poll_o
);

  localparam logic [2:0] CASC = 3'(CASCADE_LINE);
  localparam logic [2:0] SPUR = 3'(SPURIOUS_LINE);

  logic [7:0] irr_m, isr_m, last_m, trig_m;
  logic [7:0] irr_s, isr_s, last_s, trig_s;
  logic [7:0] in_m, in_s;

  assign in_m = irq_i[7:0];
  assign in_s = irq_i[15:8];

  function automatic logic [3:0] top_line(input logic [7:0] v);
    top_line = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (v[i]) top_line = 4'(i);
  endfunction

  logic [3:0] m_pri, m_cur, s_pri, s_cur;
  logic       m_win, s_win, m_casc;
  logic [2:0] m_line, s_line;

  assign m_pri  = top_line(irr_m);
  assign m_cur  = top_line(isr_m);
  assign s_pri  = top_line(irr_s);
  assign s_cur  = top_line(isr_s);
  assign m_win  = m_pri < m_cur;
  assign s_win  = s_pri < s_cur;
  assign m_line = m_pri[2:0];
  assign s_line = s_pri[2:0];
  assign m_casc = m_win && (m_line == CASC);
  assign irq_o  = m_win;

  logic do_pc, do_pm, do_ps;
  assign do_pc = poll_c_i & ~ack_i;
  assign do_pm = poll_m_i & ~ack_i & ~poll_c_i;
  assign do_ps = poll_s_i & ~ack_i & ~poll_c_i & ~poll_m_i;

  logic [7:0] m_oh, s_oh, c_oh;
  assign m_oh = 8'd1 << m_line;
  assign s_oh = 8'd1 << s_line;
  assign c_oh = 8'd1 << CASC;

  logic m_take, m_poll_clr, s_take, s_poll_clr, s_ack;
  assign m_take     = (ack_i | do_pm | do_pc) & m_win;
  assign m_poll_clr = (do_pm | do_pc) & m_win;
  assign s_ack      = ack_i & m_casc & s_win;
  assign s_poll_clr = ((do_pc & m_casc) | do_ps) & s_win;
  assign s_take     = s_ack | s_poll_clr;

  logic [7:0] m_clr_irr, m_clr_isr, m_set_isr;
  logic [7:0] s_clr_irr, s_clr_isr, s_set_isr;
  assign m_clr_isr = (m_poll_clr ? m_oh : 8'd0) | ((do_ps & s_win) ? c_oh : 8'd0);
  assign m_clr_irr = (m_take ? m_oh : 8'd0) | ((do_ps & s_win) ? c_oh : 8'd0);
  assign m_set_isr = (ack_i & m_win) ? m_oh : 8'd0;
  assign s_clr_irr = s_take ? s_oh : 8'd0;
  assign s_clr_isr = s_poll_clr ? s_oh : 8'd0;
  assign s_set_isr = s_ack ? s_oh : 8'd0;

  logic [7:0] irr_m_nx, irr_s_nx;
  always_comb begin
    irr_m_nx = (trig_m & in_m) | (~trig_m & ((irr_m & ~m_clr_irr) | (in_m & ~last_m)));
    irr_m_nx[CASCADE_LINE] = (irr_m[CASCADE_LINE] | s_win) & ~m_clr_irr[CASCADE_LINE];
    irr_s_nx = (trig_s & in_s) | (~trig_s & ((irr_s & ~s_clr_irr) | (in_s & ~last_s)));
  end

  logic [2:0] s_code;
  logic [7:0] vec_nx;
  logic [3:0] poll_nx;
  assign s_code = s_win ? s_line : SPUR;

  always_comb begin
    if (!m_win)      vec_nx = {base_m_i, SPUR};
    else if (m_casc) vec_nx = {base_s_i, s_code};
    else             vec_nx = {base_m_i, m_line};
    if (do_pc)
      poll_nx = m_casc ? (4'd8 + {1'b0, s_code}) : {1'b0, m_win ? m_line : SPUR};
    else if (do_pm)
      poll_nx = {1'b0, m_win ? m_line : SPUR};
    else
      poll_nx = {1'b0, s_code};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_m <= '0; isr_m <= '0; last_m <= '0; trig_m <= '0;
      irr_s <= '0; isr_s <= '0; last_s <= '0; trig_s <= '0;
      vector_o <= '0;
      poll_o <= '0;
    end else begin
      last_m <= in_m;
      last_s <= in_s;
      irr_m  <= irr_m_nx;
      irr_s  <= irr_s_nx;
      isr_m  <= (isr_m & ~m_clr_isr) | m_set_isr;
      isr_s  <= (isr_s & ~s_clr_isr) | s_set_isr;
      if (trig_wr_m_i) trig_m <= trig_wdata_i & TRIG_MASK_M;
      if (trig_wr_s_i) trig_s <= trig_wdata_i & TRIG_MASK_S;
      if (ack_i) vector_o <= vec_nx;
      if (do_pc | do_pm | do_ps) poll_o <= poll_nx;
    end
  end

  // R2: a raised request always has a pending primary line behind it
  assert_irq_has_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irr_m != 8'd0));

  // R4: acknowledged ordinary primary line goes in service and is named in the vector
  assert_ack_primary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && m_win && !m_casc) |=>
      (vector_o == {$past(base_m_i), $past(m_line)}) && isr_m[$past(m_line)]);

  // R7: acknowledge with no winner leaves in-service state alone
  assert_ack_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !m_win) |=> (vector_o[2:0] == SPUR) && (isr_m == $past(isr_m))
                          && (isr_s == $past(isr_s)));

  // R8: primary poll without winner reports the spurious line
  assert_poll_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_m_i && !poll_c_i && !ack_i && !m_win) |=> (poll_o == {1'b0, SPUR}));

  // R9: a successful secondary poll drops the primary cascade line
  assert_poll_slave_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ps && s_win) |=> !isr_m[CASCADE_LINE] && !irr_m[CASCADE_LINE]);

  // R12: the poll output holds whenever no poll is taken
  assert_poll_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i || !(poll_m_i || poll_s_i || poll_c_i)) |=> $stable(poll_o));

  // R13: the vector holds outside acknowledges
  assert_vector_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> $stable(vector_o));

endmodule

// File: tb/sim_cascade_irq_ctrl.sv
module sim_cascade_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic ack = 0, pm = 0, ps = 0, pc = 0;
  logic [4:0] bm = 5'h04, bs = 5'h0E;
  logic twm = 0, tws = 0;
  logic [7:0] twd = '0;
  logic irq_o;
  logic [7:0] vec;
  logic [3:0] pol;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cascade_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .ack_i(ack),
    .poll_m_i(pm), .poll_s_i(ps), .poll_c_i(pc),
    .base_m_i(bm), .base_s_i(bs),
    .trig_wr_m_i(twm), .trig_wr_s_i(tws), .trig_wdata_i(twd),
    .irq_o(irq_o), .vector_o(vec), .poll_o(pol)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic reset_all();
    irq = '0; ack = 0; pm = 0; ps = 0; pc = 0; twm = 0; tws = 0;
    rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  task automatic do_ack(); ack = 1; step(); ack = 0; endtask
  task automatic do_pm();  pm = 1; step(); pm = 0; endtask
  task automatic do_ps();  ps = 1; step(); ps = 0; endtask
  task automatic do_pc();  pc = 1; step(); pc = 0; endtask

  task automatic t_reset();
    reset_all();
    chk("R1 irq", irq_o, 0);
    chk("R1 vector", vec, 0);
    chk("R1 poll", pol, 0);
    irq[3] = 1; step(); irq[3] = 0; step();
    do_pm(); chk("R1 edge default poll", pol, 3);
    chk("R1 edge default irq", irq_o, 0);
  endtask

  task automatic t_primary();
    reset_all();
    irq[5] = 1; step();
    chk("R2 irq after edge", irq_o, 1);
    do_ack();
    chk("R4 vector line5", vec, 8'h25);
    chk("R4 irq after ack", irq_o, 0);
    irq[6] = 1; step();
    chk("R4 lower line blocked", irq_o, 0);
    irq[1] = 1; step();
    chk("R2 higher beats in-service", irq_o, 1);
    do_ack();
    chk("R4 vector line1", vec, 8'h21);
    chk("R4 nested blocks line6", irq_o, 0);
  endtask

  task automatic t_cascade();
    reset_all();
    irq[2] = 1; step(); step(); step();
    chk("R3 external line2 ignored", irq_o, 0);
    irq[2] = 0; irq[11] = 1; step();
    chk("R3 cascade not yet", irq_o, 0);
    step();
    chk("R3 cascade raised", irq_o, 1);
    do_ack();
    chk("R5 slave vector", vec, 8'h73);
    chk("R5 irq low after cascade ack", irq_o, 0);
    step();
    chk("R5 irq stays low", irq_o, 0);
  endtask

  task automatic t_spurious_slave();
    reset_all();
    twd = 8'hFF; tws = 1; step(); tws = 0;
    irq[9] = 1; step(); step();
    chk("R6 cascade via level line", irq_o, 1);
    irq[9] = 0; step();
    chk("R6 cascade held", irq_o, 1);
    do_ack();
    chk("R6 spurious slave vector", vec, 8'h77);
    irq[9] = 1; step();
    do_ps();
    chk("R6 slave state untouched", pol, 1);
  endtask

  task automatic t_no_winner();
    reset_all();
    do_ack();
    chk("R7 empty vector", vec, 8'h27);
    chk("R7 irq low", irq_o, 0);
    irq[4] = 1; step();
    do_ack();
    chk("R7 no state left behind", vec, 8'h24);
    step(); step();
    chk("R13 vector held", vec, 8'h24);
  endtask

  task automatic t_poll_primary();
    reset_all();
    irq[3] = 1; irq[6] = 1; step();
    do_pm(); chk("R8 poll line3", pol, 3);
    chk("R8 line6 still requests", irq_o, 1);
    do_pm(); chk("R8 poll line6", pol, 6);
    do_pm(); chk("R8 poll empty", pol, 7);
    chk("R8 irq low", irq_o, 0);
  endtask

  task automatic t_poll_slave();
    reset_all();
    irq[13] = 1; step(); step();
    chk("R9 cascade up", irq_o, 1);
    do_ps();
    chk("R9 slave poll line5", pol, 5);
    chk("R9 primary line2 cleared", irq_o, 0);
    do_ps(); chk("R9 slave poll empty", pol, 7);
    irq[12] = 1; step(); step();
    do_pc(); chk("R10 combined slave", pol, 12);
    chk("R10 irq low after combined", irq_o, 0);
    irq[1] = 1; step();
    do_pc(); chk("R10 combined primary", pol, 1);
    do_pc(); chk("R10 combined empty", pol, 7);
  endtask

  task automatic t_trigger();
    reset_all();
    twd = 8'hFF; twm = 1; tws = 1; step(); twm = 0; tws = 0;
    irq[0] = 1; irq[3] = 1; step();
    do_pm(); chk("R11 masked line0", pol, 0);
    do_pm(); chk("R11 level line3", pol, 3);
    do_pm(); chk("R11 level line3 again", pol, 3);
    irq[3] = 0; step();
    chk("R11 line0 edge only", irq_o, 0);
    irq[0] = 0;
    irq[8] = 1; irq[9] = 1; step();
    do_ps(); chk("R11 slave line0 masked", pol, 0);
    do_ps(); chk("R11 slave level line1", pol, 1);
    do_ps(); chk("R11 slave level line1 again", pol, 1);
    irq[9] = 0; step(); step();
    do_ps(); chk("R11 slave line0 edge only", pol, 7);
  endtask

  task automatic t_same_cycle();
    reset_all();
    irq[5] = 1; step();
    ack = 1; pm = 1; irq[1] = 1; step(); ack = 0; pm = 0;
    chk("R12 ack vector", vec, 8'h25);
    chk("R12 poll ignored", pol, 0);
    chk("R2 new edge during ack", irq_o, 1);
    do_ack();
    chk("R4 second vector", vec, 8'h21);
  endtask

  initial begin
    t_reset();
    t_primary();
    t_cascade();
    t_spurious_slave();
    t_no_winner();
    t_poll_primary();
    t_poll_slave();
    t_trigger();
    t_same_cycle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule